// File: doc/BRIEF.md
# High Speed Packet Receive Deframer

This block sits behind clock and data recovery on a 480 Mb/s serial receive path. Each clock it takes one recovered line symbol and a squelch level that says whether any signal is on the wire. It hunts for the alternating synchronisation preamble and locks on when that preamble ends. From then on it turns the NRZI symbols back into bits, strips the zeros inserted after runs of ones, and packs the result into bytes, first bit received in the least significant position.

A packet ends in one of two ways. Normally the transmitter sends a deliberate run of seven ones, which cannot occur in stuffed data. The block reports this as end of packet and flags it when the bits before the marker do not fill whole bytes. If squelch returns before the marker arrives, the packet is reported as truncated. CRC checking and interpretation of packet identifiers happen further down the path.

Top module: `hs_rx_deframer`

## Requirements
- R1: After reset, and in every cycle following one in which squelch was sampled high, rxValid and rxEop are low. Reset clears all output strobes.
- R2: The line symbol is 1 for J and 0 for K. A decoded bit is 1 when the symbol equals the previous one and 0 when it differs. The first symbol after squelch goes low is not decoded; it is only stored for comparison.
- R3: Sync ends at the first decoded 1 that follows at least SYNC_MIN_ZEROS (default 8) decoded zeros. A 12-symbol preamble (K, ten alternations, K) is accepted.
- R4: A decoded 1 that follows fewer than SYNC_MIN_ZEROS zeros does not lock. The hunt restarts its zero count and a later valid preamble on the same burst still locks.
- R5: After lock, a decoded 0 that follows six consecutive accepted ones is dropped. The ones count starts from zero at lock.
- R6: Accepted bits are packed into bytes least significant bit first. rxValid pulses for one cycle with rxByte in the cycle after the edge that sampled the byte's last symbol.
- R7: rxSop is high together with rxValid on the first byte after lock only.
- R8: A decoded 1 that follows six accepted ones is the end marker. rxEop pulses for one cycle after the edge that sampled it. The unfinished byte is dropped, and the line is ignored until squelch rises again.
- R9: The end is clean when exactly seven bits of the current byte were accepted before the marker. Otherwise rxAlignErr pulses with rxEop; a byte completed from marker bits may then have been delivered.
- R10: If squelch rises while a packet is being received, rxTrunc pulses one cycle later and the unfinished byte is dropped. Squelch takes priority over a byte completion or an end marker sampled on the same edge: neither rxValid nor rxEop appears.
- R11: If squelch rises during the preamble hunt, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock, one symbol per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| squelch | input | 1 | High when no signal is present on the line |
| lineSym | input | 1 | Recovered line symbol, 1 = J, 0 = K |
| rxByte | output | BYTE_W | Assembled byte, valid while rxValid is high |
| rxValid | output | 1 | One-cycle strobe for a new byte |
| rxSop | output | 1 | First byte of a packet, with rxValid |
| rxEop | output | 1 | End marker seen |
| rxAlignErr | output | 1 | End marker not on a byte boundary, with rxEop |
| rxTrunc | output | 1 | Packet cut off by squelch |

## Verification
Squelch can rise on the same edge that would otherwise complete a byte, or on the same edge that samples the seventh one of the end marker. The bench drives the rising squelch together with the final data symbol, or together with the last marker symbol. In the cycle after that edge it requires rxTrunc high with rxValid and rxEop both low, and it requires that no extra byte appears afterwards.

// File: rtl/hsdf_pkg.sv
package hsdf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } hsdfState_e;

  // control -> datapath
  typedef struct packed {
    logic run;    // line active, symbols are tracked
    logic hunt;   // searching for end of preamble
    logic data;   // packet body being decoded
    logic trunc;  // packet lost to squelch this cycle
  } hsdfCtl_t;

  // datapath -> control
  typedef struct packed {
    logic syncHit;
    logic violation;
  } hsdfStat_t;

endpackage

// File: rtl/hsdf_ctrl.sv
module hsdf_ctrl
  import hsdf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      squelch,
  input  hsdfStat_t stat,
  output hsdfCtl_t  ctl
);

  hsdfState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (!squelch) stateNxt = ST_HUNT;
      ST_HUNT: begin
        if (squelch)           stateNxt = ST_IDLE;
        else if (stat.syncHit) stateNxt = ST_DATA;
      end
      ST_DATA: begin
        if (squelch)             stateNxt = ST_IDLE;
        else if (stat.violation) stateNxt = ST_DONE;
      end
      ST_DONE: if (squelch) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl.run   = !squelch && (state != ST_DONE);
    ctl.hunt  = !squelch && (state == ST_HUNT);
    ctl.data  = !squelch && (state == ST_DATA);
    ctl.trunc =  squelch && (state == ST_DATA);
  end

endmodule

// File: rtl/hsdf_datapath.sv
module hsdf_datapath
  import hsdf_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int SYNC_MIN_ZEROS = 8,
  parameter int STUFF_RUN      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineSym,
  input  hsdfCtl_t          ctl,
  output hsdfStat_t         stat,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              rxSop,
  output logic              rxEop,
  output logic              rxAlignErr,
  output logic              rxTrunc
);

  localparam int ZW = $clog2(SYNC_MIN_ZEROS + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [ZW-1:0] Z_MIN  = ZW'(SYNC_MIN_ZEROS);
  localparam logic [OW-1:0] O_RUN  = OW'(STUFF_RUN);
  localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

  logic              prevSym, primed;
  logic [ZW-1:0]     zeroCnt;
  logic [OW-1:0]     onesCnt;
  logic [BW-1:0]     bitCnt;
  logic [BYTE_W-1:0] shReg;
  logic              firstPend;

  logic decBit, bitOk, inData, stuffed, violation, accept, byteDone, syncHit;
  logic [BYTE_W-1:0] byteNxt;

  always_comb begin
    decBit    = (lineSym == prevSym);
    bitOk     = ctl.run && primed;
    syncHit   = ctl.hunt && bitOk && decBit && (zeroCnt >= Z_MIN);
    inData    = ctl.data && bitOk;
    stuffed   = inData && !decBit && (onesCnt == O_RUN);
    violation = inData &&  decBit && (onesCnt == O_RUN);
    accept    = inData && !stuffed && !violation;
    byteDone  = accept && (bitCnt == B_LAST);
    byteNxt   = {decBit, shReg[BYTE_W-1:1]};
    stat.syncHit   = syncHit;
    stat.violation = violation;
  end

  // symbol history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed  <= 1'b0;
      prevSym <= 1'b0;
    end else if (!ctl.run) begin
      primed  <= 1'b0;
    end else begin
      primed  <= 1'b1;
      prevSym <= lineSym;
    end
  end

  // preamble hunt
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.hunt) begin
      zeroCnt <= '0;
    end else if (bitOk) begin
      if (decBit)              zeroCnt <= '0;
      else if (zeroCnt < Z_MIN) zeroCnt <= zeroCnt + 1'b1;
    end
  end

  // destuffing and byte assembly
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.data) begin
      onesCnt <= '0;
      bitCnt  <= '0;
      shReg   <= '0;
    end else if (stuffed) begin
      onesCnt <= '0;
    end else if (accept) begin
      onesCnt <= decBit ? onesCnt + 1'b1 : '0;
      bitCnt  <= (bitCnt == B_LAST) ? '0 : bitCnt + 1'b1;
      shReg   <= byteNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         firstPend <= 1'b0;
    else if (syncHit)  firstPend <= 1'b1;
    else if (byteDone || !ctl.run) firstPend <= 1'b0;
  end

  // output strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte     <= '0;
      rxValid    <= 1'b0;
      rxSop      <= 1'b0;
      rxEop      <= 1'b0;
      rxAlignErr <= 1'b0;
      rxTrunc    <= 1'b0;
    end else begin
      if (byteDone) rxByte <= byteNxt;
      rxValid    <= byteDone;
      rxSop      <= byteDone && firstPend;
      rxEop      <= violation;
      rxAlignErr <= violation && (bitCnt != B_LAST);
      rxTrunc    <= ctl.trunc;
    end
  end

endmodule

// File: rtl/hs_rx_deframer.sv
module hs_rx_deframer
  import hsdf_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int SYNC_MIN_ZEROS = 8,
  parameter int STUFF_RUN      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              squelch,
  input  logic              lineSym,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid,
  output logic              rxSop,
  output logic              rxEop,
  output logic              rxAlignErr,
  output logic              rxTrunc
);

  hsdfCtl_t  ctl;
  hsdfStat_t stat;

  hsdf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .squelch (squelch),
    .stat    (stat),
    .ctl     (ctl)
  );

  hsdf_datapath #(
    .BYTE_W         (BYTE_W),
    .SYNC_MIN_ZEROS (SYNC_MIN_ZEROS),
    .STUFF_RUN      (STUFF_RUN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineSym    (lineSym),
    .ctl        (ctl),
    .stat       (stat),
    .rxByte     (rxByte),
    .rxValid    (rxValid),
    .rxSop      (rxSop),
    .rxEop      (rxEop),
    .rxAlignErr (rxAlignErr),
    .rxTrunc    (rxTrunc)
  );

endmodule

// File: rtl/hs_rx_deframer_chk.sv
module hs_rx_deframer_chk (
  input logic clk,
  input logic rstN,
  input logic squelch,
  input logic rxValid,
  input logic rxSop,
  input logic rxEop,
  input logic rxAlignErr,
  input logic rxTrunc
);

  p_squelch_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    squelch |=> (!rxValid && !rxEop));

  p_byte_spacing_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_sop_with_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxSop |-> rxValid);

  p_eop_no_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxEop |-> (!rxValid && !rxTrunc));

  p_align_with_eop_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxAlignErr |-> rxEop);

  p_trunc_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxTrunc |-> ($past(squelch) && !rxValid));

endmodule

bind hs_rx_deframer hs_rx_deframer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .squelch    (squelch),
  .rxValid    (rxValid),
  .rxSop      (rxSop),
  .rxEop      (rxEop),
  .rxAlignErr (rxAlignErr),
  .rxTrunc    (rxTrunc)
);

// File: tb/sim_hs_rx_deframer.sv
module sim_hs_rx_deframer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       squelch = 1'b1;
  logic       lineSym = 1'b1;
  logic [7:0] rxByte;
  logic       rxValid, rxSop, rxEop, rxAlignErr, rxTrunc;

  hs_rx_deframer u0 (
    .clk(clk), .rstN(rstN), .squelch(squelch), .lineSym(lineSym),
    .rxByte(rxByte), .rxValid(rxValid), .rxSop(rxSop), .rxEop(rxEop),
    .rxAlignErr(rxAlignErr), .rxTrunc(rxTrunc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nTests = 0;
  int nFail  = 0;
  logic done = 1'b0;

  // line encoder state
  logic curSym = 1'b1;
  int   onesRun = 0;

  // monitor log
  logic [7:0] logBytes [0:63];
  int nBytes = 0, nSop = 0, sopIdx = -1, nEop = 0, nAlign = 0, nTrunc = 0;

  always @(posedge clk) begin
    #1;
    if (rxValid) begin
      if (nBytes < 64) logBytes[nBytes] = rxByte;
      if (rxSop && sopIdx < 0) sopIdx = nBytes;
      nBytes++;
    end
    if (rxSop)      nSop++;
    if (rxEop)      nEop++;
    if (rxAlignErr) nAlign++;
    if (rxTrunc)    nTrunc++;
  end

  task automatic clearLog();
    nBytes = 0; nSop = 0; sopIdx = -1; nEop = 0; nAlign = 0; nTrunc = 0;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rawBit(input logic b, input logic sq);
    @(negedge clk);
    if (!b) curSym = ~curSym;
    lineSym = curSym;
    squelch = sq;
  endtask

  task automatic sendData(input logic b);
    rawBit(b, 1'b0);
    if (b) onesRun++; else onesRun = 0;
    if (onesRun == 6) begin
      rawBit(1'b0, 1'b0);
      onesRun = 0;
    end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendData(v[i]);
  endtask

  task automatic sendSync(input int n);
    @(negedge clk);
    squelch = 1'b0;
    curSym = 1'b0;
    lineSym = 1'b0;
    repeat (n - 2) rawBit(1'b0, 1'b0);
    rawBit(1'b1, 1'b0);
    onesRun = 0;
  endtask

  task automatic sendEop();
    rawBit(1'b0, 1'b0);
    repeat (7) rawBit(1'b1, 1'b0);
  endtask

  task automatic endBurst();
    @(negedge clk);
    squelch = 1'b1;
    lineSym = 1'b1;
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic sampleAfterEdge();
    @(posedge clk);
    #2;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    sampleAfterEdge();
    check(!rxValid && !rxSop && !rxEop && !rxAlignErr && !rxTrunc,
          "R1 reset strobes", {rxValid, rxSop, rxEop, rxAlignErr, rxTrunc}, 0);
    check(rxByte == 8'h00, "R1 reset byte", rxByte, 0);
  endtask

  task automatic testBasic();
    clearLog();
    sendSync(32);
    sendByte(8'hA5);
    sampleAfterEdge();
    check(rxValid && rxByte == 8'hA5, "R6 byte timing", {rxValid, rxByte}, {1'b1, 8'hA5});
    check(rxSop, "R7 sop on first byte", rxSop, 1);
    sendByte(8'h3C);
    sendEop();
    sampleAfterEdge();
    check(rxEop && !rxAlignErr, "R8 eop timing clean", {rxEop, rxAlignErr}, 2'b10);
    endBurst();
    check(nBytes == 2, "R2 byte count", nBytes, 2);
    check(logBytes[0] == 8'hA5 && logBytes[1] == 8'h3C, "R6 byte values",
          {logBytes[0], logBytes[1]}, 16'hA53C);
    check(nSop == 1 && sopIdx == 0, "R7 single sop", nSop, 1);
    check(nEop == 1 && nAlign == 0 && nTrunc == 0, "R8 single eop", nEop, 1);
  endtask

  task automatic testShortSync();
    clearLog();
    sendSync(12);
    sendByte(8'h69);
    sendEop();
    endBurst();
    check(nBytes == 1 && logBytes[0] == 8'h69, "R3 twelve symbol sync", logBytes[0], 8'h69);
    check(nEop == 1 && nAlign == 0, "R3 eop after short sync", nEop, 1);
  endtask

  task automatic testFalseSync();
    clearLog();
    sendSync(6);
    repeat (10) rawBit(1'b0, 1'b0);
    rawBit(1'b1, 1'b0);
    onesRun = 0;
    sendByte(8'hC3);
    sendEop();
    endBurst();
    check(nBytes == 1 && logBytes[0] == 8'hC3, "R4 relock after short run", logBytes[0], 8'hC3);
    check(nSop == 1 && nEop == 1 && nAlign == 0, "R4 single clean packet", {nSop, nEop}, 2);
  endtask

  task automatic testStuffing();
    clearLog();
    sendSync(32);
    sendByte(8'hFF);
    sendByte(8'hFF);
    sendByte(8'h7E);
    sendByte(8'h3F);
    sendEop();
    endBurst();
    check(nBytes == 4, "R5 stuffed byte count", nBytes, 4);
    check(logBytes[0] == 8'hFF && logBytes[1] == 8'hFF &&
          logBytes[2] == 8'h7E && logBytes[3] == 8'h3F, "R5 stuffed values",
          {logBytes[2], logBytes[3]}, 16'h7E3F);
    check(nEop == 1 && nAlign == 0, "R5 eop after stuffing", nAlign, 0);
  endtask

  task automatic testMisaligned();
    clearLog();
    sendSync(32);
    sendByte(8'h12);
    sendData(1'b1); sendData(1'b0); sendData(1'b1);
    sendEop();
    sampleAfterEdge();
    check(rxEop && rxAlignErr, "R9 align error with eop", {rxEop, rxAlignErr}, 2'b11);
    endBurst();
    check(nBytes == 2 && logBytes[0] == 8'h12 && logBytes[1] == 8'hF5,
          "R9 bytes before marker", logBytes[1], 8'hF5);
  endtask

  task automatic testTruncate();
    clearLog();
    sendSync(32);
    sendByte(8'h55);
    repeat (4) sendData(1'b1);
    @(negedge clk);
    squelch = 1'b1;
    sampleAfterEdge();
    check(rxTrunc && !rxEop, "R10 trunc strobe", {rxTrunc, rxEop}, 2'b10);
    endBurst();
    check(nBytes == 1 && nEop == 0 && nTrunc == 1, "R10 partial dropped", nBytes, 1);
  endtask

  task automatic testSquelchOnByte();
    clearLog();
    sendSync(32);
    sendByte(8'h81);
    repeat (7) sendData(1'b0);
    rawBit(1'b0, 1'b1);
    sampleAfterEdge();
    check(rxTrunc && !rxValid, "R10 squelch beats byte", {rxTrunc, rxValid}, 2'b10);
    endBurst();
    check(nBytes == 1 && logBytes[0] == 8'h81, "R10 only first byte", nBytes, 1);
  endtask

  task automatic testSquelchOnEop();
    clearLog();
    sendSync(32);
    sendByte(8'h0F);
    rawBit(1'b0, 1'b0);
    repeat (6) rawBit(1'b1, 1'b0);
    rawBit(1'b1, 1'b1);
    sampleAfterEdge();
    check(rxTrunc && !rxEop, "R10 squelch beats marker", {rxTrunc, rxEop}, 2'b10);
    endBurst();
    check(nEop == 0 && nAlign == 0 && nBytes == 1, "R10 no eop logged", nEop, 0);
  endtask

  task automatic testAfterEop();
    clearLog();
    sendSync(32);
    sendByte(8'hE7);
    sendEop();
    repeat (16) rawBit(1'b0, 1'b0);
    rawBit(1'b1, 1'b0);
    onesRun = 0;
    sendByte(8'h42);
    sendEop();
    endBurst();
    check(nBytes == 1 && logBytes[0] == 8'hE7, "R8 line ignored after eop", nBytes, 1);
    check(nEop == 1 && nSop == 1, "R8 one eop only", nEop, 1);
  endtask

  task automatic testHuntSquelch();
    clearLog();
    sendSync(6);
    repeat (3) rawBit(1'b0, 1'b0);
    endBurst();
    check(nBytes == 0 && nEop == 0 && nTrunc == 0 && nSop == 0, "R11 hunt quiet",
          nBytes + nEop + nTrunc, 0);
    sendSync(20);
    sendByte(8'h99);
    sendEop();
    endBurst();
    check(nBytes == 1 && logBytes[0] == 8'h99, "R11 recovers after hunt", logBytes[0], 8'h99);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testShortSync();
    testFalseSync();
    testStuffing();
    testMisaligned();
    testTruncate();
    testSquelchOnByte();
    testSquelchOnEop();
    testAfterEop();
    testHuntSquelch();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule